// File: doc/BRIEF.md
# Indexed performance counter bank

This block holds a small set of event counters for a processor core. Each counter watches one countable condition. A per-counter condition number picks that condition from a vector of one-bit event inputs. Software reaches every counter through one narrow register window. It first writes an index register, and the configuration, count and snapshot registers then act on the counter that the index selects.

A single enable bit starts and stops the whole bank at once. Condition number 0 never fires, so giving a counter condition 0 is the way to park that counter alone. The snapshot bit copies the selected counter into a held high/low pair, so software can read a wide value in two accesses without tearing. The live count can be preset through its low and high words. Counters wrap silently modulo 2^W, and software works with differences.

Two read-only build words let software discover the bank. One reports presence, the number of counters and the width code. The other reports presence and the number of conditions. A second index selects one condition, and two name words then return that condition's 8-character label.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every counter and condition number is 0, the global enable is 0, and both index registers read 0.
- R2: The counter index (address 0) selects the counter used by the config (2), count-low (3), count-high (4), snapshot-low (5) and snapshot-high (6) registers. When the index is at or above the counter count, those registers read 0, and writes and snapshot requests change nothing.
- R3: Control register (address 1) bit 0 is the global enable. While it is 0, no counter advances. Bits 31:16 of the control register read back as last written.
- R4: A counter advances by exactly 1 on each clock where the enable is 1, its condition number c is nonzero and event input bit c is high. A counter with condition 0 holds its value whatever the event inputs do.
- R5: Writing control bit 1 as 1 copies the selected counter into the snapshot pair on that same clock edge. The copy holds the value from before any increment on that edge. Control bit 1 always reads back as 0.
- R6: Writing count-low loads counter bits 31:0, and writing count-high loads bits W-1:32 from write-data bits W-33:0. Such a write wins over an increment on the same clock.
- R7: Counters are W = 32+16*s bits wide (s = 1 by default, giving 48 bits) and wrap from all ones to 0.
- R8: The counter build word (address 7) reads {14'b0, s[1:0], counters[7:0], 8'h01}. Writes to it are ignored.
- R9: The condition index (address 8) selects a condition. The name words at 9 and 10 hold characters 0..3 and 4..7, with character 0 in bits 7:0. Condition 0 is named "NEVER" padded with three spaces. Condition j>0 is named "EVNT" followed by j as four upper-case hex digits. An index at or above the condition count makes both name words read 0.
- R10: The condition build word (address 11) reads {16'b0, conditions[7:0], 8'h01}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Single-cycle write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt | input | NUM_COND | One-bit event inputs, bit c feeds condition c |

## Verification
Two pairs of functions can fall on one clock edge. The first pair is a snapshot request and an increment of the same counter. The second is a count preset and an increment. The bench holds the selected event high while it issues the control or count-low write. It then checks that the snapshot holds the value from before the edge while the live counter has moved on, and that the preset value stands with no added count.

// File: rtl/perf_pkg.sv
package perf_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 16;
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_SNAP_BIT = 1;
  localparam logic [7:0] BUILD_VERSION = 8'h01;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTR_IDX    = 4'd0,
    RA_CTL        = 4'd1,
    RA_CFG        = 4'd2,
    RA_CNT_LO     = 4'd3,
    RA_CNT_HI     = 4'd4,
    RA_SNAP_LO    = 4'd5,
    RA_SNAP_HI    = 4'd6,
    RA_CTR_BUILD  = 4'd7,
    RA_COND_IDX   = 4'd8,
    RA_NAME_A     = 4'd9,
    RA_NAME_B     = 4'd10,
    RA_COND_BUILD = 4'd11,
    RA_NONE_C     = 4'd12,
    RA_NONE_D     = 4'd13,
    RA_NONE_E     = 4'd14,
    RA_NONE_F     = 4'd15
  } regAddr_e;

  // strobes from control to datapath, already qualified by a valid index
  typedef struct packed {
    logic wrCfg;
    logic wrLo;
    logic wrHi;
    logic takeSnap;
  } dpStrobe_t;

  function automatic logic [7:0] hexAscii(input logic [3:0] nib);
    if (nib < 4'd10) hexAscii = 8'h30 + {4'b0, nib};
    else             hexAscii = 8'h37 + {4'b0, nib};
  endfunction

endpackage

// File: rtl/perf_ctl.sv
module perf_ctl
  import perf_pkg::*;
#(
  parameter int NUM_CTR  = 4,
  parameter int NUM_COND = 8,
  parameter int SIZE_SEL = 1,
  parameter int CW       = 3,
  parameter int W        = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [IDX_W-1:0]  ctrIdx,
  output logic              globalEn,
  output dpStrobe_t         strobe,
  input  logic [CW-1:0]     selCfg,
  input  logic [W-1:0]      selCnt,
  input  logic [W-1:0]      snapVal
);

  localparam logic [IDX_W-1:0] NUM_CTR_V  = IDX_W'(NUM_CTR);
  localparam logic [IDX_W-1:0] NUM_COND_V = IDX_W'(NUM_COND);
  localparam logic [DATA_W-1:0] CTR_BUILD_WORD =
    {14'b0, 2'(SIZE_SEL), 8'(NUM_CTR), BUILD_VERSION};
  localparam logic [DATA_W-1:0] COND_BUILD_WORD =
    {16'b0, 8'(NUM_COND), BUILD_VERSION};

  regAddr_e    regSel;
  logic [IDX_W-1:0] condIdx;
  logic [15:0] ctlHi;
  logic        ctrValid;
  logic        condValid;
  logic [63:0] nameWord;

  assign regSel    = regAddr_e'(addr);
  assign ctrValid  = ctrIdx < NUM_CTR_V;
  assign condValid = condIdx < NUM_COND_V;

  function automatic logic [63:0] condName(input logic [IDX_W-1:0] j);
    logic [7:0] ch [8];
    if (j == '0) begin
      ch = '{8'h4E, 8'h45, 8'h56, 8'h45, 8'h52, 8'h20, 8'h20, 8'h20};
    end else begin
      ch[0] = 8'h45;
      ch[1] = 8'h56;
      ch[2] = 8'h4E;
      ch[3] = 8'h54;
      ch[4] = hexAscii(j[15:12]);
      ch[5] = hexAscii(j[11:8]);
      ch[6] = hexAscii(j[7:4]);
      ch[7] = hexAscii(j[3:0]);
    end
    for (int k = 0; k < 8; k++) condName[8*k +: 8] = ch[k];
  endfunction

  assign nameWord = condName(condIdx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrIdx   <= '0;
      condIdx  <= '0;
      globalEn <= 1'b0;
      ctlHi    <= '0;
    end else if (wrEn) begin
      case (regSel)
        RA_CTR_IDX:  ctrIdx <= wdata[IDX_W-1:0];
        RA_COND_IDX: condIdx <= wdata[IDX_W-1:0];
        RA_CTL: begin
          globalEn <= wdata[CTL_EN_BIT];
          ctlHi    <= wdata[31:16];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrCfg    = wrEn && ctrValid && (regSel == RA_CFG);
    strobe.wrLo     = wrEn && ctrValid && (regSel == RA_CNT_LO);
    strobe.wrHi     = wrEn && ctrValid && (regSel == RA_CNT_HI);
    strobe.takeSnap = wrEn && ctrValid && (regSel == RA_CTL) && wdata[CTL_SNAP_BIT];
  end

  always_comb begin
    rdata = '0;
    case (regSel)
      RA_CTR_IDX:    rdata = DATA_W'(ctrIdx);
      RA_CTL:        rdata = {ctlHi, 15'b0, globalEn};
      RA_CFG:        rdata = ctrValid ? DATA_W'(selCfg) : '0;
      RA_CNT_LO:     rdata = ctrValid ? selCnt[31:0] : '0;
      RA_CNT_HI:     rdata = ctrValid ? DATA_W'(selCnt[W-1:32]) : '0;
      RA_SNAP_LO:    rdata = ctrValid ? snapVal[31:0] : '0;
      RA_SNAP_HI:    rdata = ctrValid ? DATA_W'(snapVal[W-1:32]) : '0;
      RA_CTR_BUILD:  rdata = CTR_BUILD_WORD;
      RA_COND_IDX:   rdata = DATA_W'(condIdx);
      RA_NAME_A:     rdata = condValid ? nameWord[31:0] : '0;
      RA_NAME_B:     rdata = condValid ? nameWord[63:32] : '0;
      RA_COND_BUILD: rdata = COND_BUILD_WORD;
      default:       rdata = '0;
    endcase
  end

endmodule

// File: rtl/perf_dp.sv
module perf_dp
  import perf_pkg::*;
#(
  parameter int NUM_CTR  = 4,
  parameter int NUM_COND = 8,
  parameter int CW       = 3,
  parameter int W        = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dpStrobe_t            strobe,
  input  logic [IDX_W-1:0]     ctrIdx,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_COND-1:0]  evt,
  input  logic                 globalEn,
  output logic [CW-1:0]        selCfg,
  output logic [W-1:0]         selCnt,
  output logic [W-1:0]         snapVal,
  output logic [NUM_CTR*W-1:0] cntFlat
);

  localparam int HIW = W - 32;
  localparam logic [CW:0] NUM_COND_V = (CW+1)'(NUM_COND);

  logic [W-1:0]  cntArr [NUM_CTR];
  logic [CW-1:0] cfgArr [NUM_CTR];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic [CW-1:0] cfgQ;
    logic [W-1:0]  cntQ;
    logic          hit;
    logic          evtSel;
    logic          bump;

    assign hit    = (ctrIdx == IDX_W'(i));
    assign evtSel = ({1'b0, cfgQ} < NUM_COND_V) ? evt[cfgQ] : 1'b0;
    assign bump   = globalEn && (cfgQ != '0) && evtSel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfgQ <= '0;
        cntQ <= '0;
      end else begin
        if (strobe.wrCfg && hit) cfgQ <= wdata[CW-1:0];
        if ((strobe.wrLo || strobe.wrHi) && hit) begin
          if (strobe.wrLo) cntQ[31:0]  <= wdata;
          if (strobe.wrHi) cntQ[W-1:32] <= wdata[HIW-1:0];
        end else if (bump) begin
          cntQ <= cntQ + W'(1);
        end
      end
    end

    assign cntArr[i]           = cntQ;
    assign cfgArr[i]           = cfgQ;
    assign cntFlat[i*W +: W]   = cntQ;
  end

  always_comb begin
    selCnt = '0;
    selCfg = '0;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (ctrIdx == IDX_W'(k)) begin
        selCnt = cntArr[k];
        selCfg = cfgArr[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               snapVal <= '0;
    else if (strobe.takeSnap) snapVal <= selCnt;
  end

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_pkg::*;
#(
  parameter int NUM_CTR  = 4,
  parameter int NUM_COND = 8,
  parameter int SIZE_SEL = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_COND-1:0] evt
);

  localparam int W  = 32 + 16 * SIZE_SEL;
  localparam int CW = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;

  dpStrobe_t            strobe;
  logic [IDX_W-1:0]     ctrIdx;
  logic                 globalEn;
  logic [CW-1:0]        selCfg;
  logic [W-1:0]         selCnt;
  logic [W-1:0]         snapVal;
  logic [NUM_CTR*W-1:0] cntFlat;

  perf_ctl #(
    .NUM_CTR(NUM_CTR), .NUM_COND(NUM_COND), .SIZE_SEL(SIZE_SEL), .CW(CW), .W(W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrEn(wr_en), .wdata(wdata),
    .rdata(rdata), .ctrIdx(ctrIdx), .globalEn(globalEn), .strobe(strobe),
    .selCfg(selCfg), .selCnt(selCnt), .snapVal(snapVal)
  );

  perf_dp #(
    .NUM_CTR(NUM_CTR), .NUM_COND(NUM_COND), .CW(CW), .W(W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ctrIdx(ctrIdx), .wdata(wdata),
    .evt(evt), .globalEn(globalEn), .selCfg(selCfg), .selCnt(selCnt),
    .snapVal(snapVal), .cntFlat(cntFlat)
  );

endmodule

// File: rtl/perf_ctr_bank_chk.sv
module perf_ctr_bank_chk
  import perf_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int W       = 48
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    addr,
  input logic                 wr_en,
  input logic [DATA_W-1:0]    wdata,
  input logic [DATA_W-1:0]    rdata,
  input logic [IDX_W-1:0]     ctrIdx,
  input logic                 globalEn,
  input logic [NUM_CTR*W-1:0] cntFlat
);

  logic wrCnt;
  logic oorWindow;
  assign wrCnt     = wr_en && (addr == RA_CNT_LO || addr == RA_CNT_HI);
  assign oorWindow = (ctrIdx >= IDX_W'(NUM_CTR)) &&
                     (addr inside {RA_CFG, RA_CNT_LO, RA_CNT_HI, RA_SNAP_LO, RA_SNAP_HI});

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!globalEn && !wrCnt) |=> $stable(cntFlat)); // R3

  AST_SNAP_BIT_READS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == RA_CTL) |-> (rdata[CTL_SNAP_BIT] == 1'b0)); // R5

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    oorWindow |-> (rdata == '0)); // R2

  AST_PRESET_BEATS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_CNT_LO && ctrIdx == '0) |=> (cntFlat[31:0] == $past(wdata))); // R6

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_step
    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !wrCnt |=> ((cntFlat[i*W +: W] - $past(cntFlat[i*W +: W])) <= W'(1))); // R4
  end

endmodule

bind perf_ctr_bank perf_ctr_bank_chk #(.NUM_CTR(NUM_CTR), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .ctrIdx(ctrIdx), .globalEn(globalEn), .cntFlat(cntFlat)
);

// File: tb/perf_ctr_bank_tb.sv
`timescale 1ns/100ps
module perf_ctr_bank_tb;

  localparam int NUM_CTR  = 4;
  localparam int NUM_COND = 8;
  localparam int SIZE_SEL = 1;
  localparam logic [31:0] CTLHI = 32'hABCD_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NUM_COND-1:0] evt = '0;

  typedef struct {
    logic [31:0] exp;
    logic [3:0]  a;
    string       tag;
  } item_t;

  item_t expQ[$];
  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  perf_ctr_bank #(.NUM_CTR(NUM_CTR), .NUM_COND(NUM_COND), .SIZE_SEL(SIZE_SEL)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .evt(evt)
  );

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    it.exp = e; it.a = a; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic pulse(input logic [NUM_COND-1:0] v, input int n);
    evt = v;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  task automatic rdCtr(input int idx, input logic [31:0] lo, input string tag);
    wr(4'd0, 32'(idx));
    rd(4'd3, lo, tag);
  endtask

  function automatic logic [63:0] expName(input int j);
    string s;
    logic [63:0] r;
    if (j == 0) s = "NEVER   ";
    else        s = {"EVNT", $sformatf("%04X", j)};
    for (int k = 0; k < 8; k++) r[8*k +: 8] = s[k];
    return r;
  endfunction

  // monitor: compares each queued expectation once the read address has settled
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        nChk++;
        if (rdata !== it.exp) begin
          nFail++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, 32'h0, "R1 ctr index");
    rd(4'd1, 32'h0, "R1 control");
    rd(4'd2, 32'h0, "R1 cfg");
    rd(4'd3, 32'h0, "R1 count lo");
    rd(4'd4, 32'h0, "R1 count hi");
    rd(4'd8, 32'h0, "R1 cond index");

    // R8 and R10 build words, R8 write ignored
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd7, {14'b0, 2'(SIZE_SEL), 8'(NUM_CTR), 8'h01}, "R8 ctr build");
    rd(4'd11, {16'b0, 8'(NUM_COND), 8'h01}, "R10 cond build");

    // R9 name directory
    for (int j = 0; j < NUM_COND; j++) begin
      logic [63:0] nm;
      nm = expName(j);
      wr(4'd8, 32'(j));
      rd(4'd9, nm[31:0], "R9 name word A");
      rd(4'd10, nm[63:32], "R9 name word B");
    end
    wr(4'd8, 32'(NUM_COND));
    rd(4'd9, 32'h0, "R9 out-of-range name A");
    rd(4'd10, 32'h0, "R9 out-of-range name B");

    // condition assignment: c0->2, c1->5, c2->0 (never), c3->7
    wr(4'd0, 32'd0); wr(4'd2, 32'd2);
    wr(4'd0, 32'd1); wr(4'd2, 32'd5);
    wr(4'd0, 32'd2); wr(4'd2, 32'd0);
    wr(4'd0, 32'd3); wr(4'd2, 32'd7);
    wr(4'd0, 32'd1);
    rd(4'd2, 32'd5, "R2 cfg readback via index");

    // R3 disabled bank does not count
    pulse('1, 4);
    rdCtr(0, 32'd0, "R3 disabled no count");

    wr(4'd1, CTLHI | 32'h1);
    rd(4'd1, CTLHI | 32'h1, "R3 control readback");

    // R4 counting patterns
    pulse(8'b1000_0101, 5);
    pulse(8'b0010_0000, 3);
    for (int k = 0; k < 6; k++) begin
      evt = (k % 2 == 0) ? 8'b0000_0100 : 8'b0;
      @(negedge clk);
    end
    evt = '0;
    rdCtr(0, 32'd8, "R4 counter0 mixed pattern");
    rdCtr(1, 32'd3, "R4 counter1");
    rdCtr(2, 32'd0, "R4 condition zero holds");
    rdCtr(3, 32'd5, "R4 counter3");

    // R5 snapshot on the same edge as an increment
    wr(4'd0, 32'd0);
    evt = 8'b0000_0100;
    wr(4'd1, CTLHI | 32'h3);
    evt = '0;
    rd(4'd6, 32'h0, "R5 snapshot hi");
    rd(4'd5, 32'd9, "R5 snapshot holds pre-edge value");
    rd(4'd3, 32'd10, "R5 live counter moved on");
    rd(4'd1, CTLHI | 32'h1, "R5 snap bit reads 0");

    // R6 preset beats a concurrent increment
    evt = 8'b0000_0100;
    wr(4'd3, 32'd500);
    evt = '0;
    rd(4'd3, 32'd500, "R6 preset wins");
    wr(4'd4, 32'h0000_1234);
    rd(4'd4, 32'h0000_1234, "R6 preset hi");
    rd(4'd3, 32'd500, "R6 lo kept");

    // R7 wrap of a full-width counter
    wr(4'd0, 32'd3);
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, 32'h0000_FFFF, "R6 hi keeps W-32 bits");
    wr(4'd3, 32'hFFFF_FFFF);
    pulse(8'b1000_0000, 2);
    rd(4'd3, 32'd1, "R7 wrap lo");
    rd(4'd4, 32'd0, "R7 wrap hi");

    // R2 out-of-range index
    wr(4'd0, 32'(NUM_CTR));
    wr(4'd2, 32'd3);
    wr(4'd3, 32'd77);
    wr(4'd1, CTLHI | 32'h3);
    rd(4'd0, 32'(NUM_CTR), "R2 index readback");
    rd(4'd2, 32'h0, "R2 oor cfg");
    rd(4'd3, 32'h0, "R2 oor count");
    rd(4'd5, 32'h0, "R2 oor snapshot");
    wr(4'd0, 32'd0);
    rd(4'd5, 32'd9, "R2 snapshot untouched");
    rd(4'd2, 32'd2, "R2 cfg untouched");
    rd(4'd3, 32'd500, "R2 counter0 untouched");
    rdCtr(3, 32'd1, "R2 counter3 untouched");

    // R3 global disable stops everything
    wr(4'd1, CTLHI);
    pulse('1, 3);
    rdCtr(0, 32'd500, "R3 disabled again");
    rd(4'd1, CTLHI, "R3 control upper kept");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule